// File: doc/BRIEF.md
# Timed I/O Command Executor

This block carries out one command at a time on a bank of 32 output ports and 32 input ports. A 52-bit command arrives with a one-cycle valid strobe. A 3-bit opcode in the top bits selects the operation. The executor can hold one output port high for a programmed number of cycles. It can sample one input port after a programmed wait. It can also drive an 8-bit value for a single cycle, with each bit placed on its own freely chosen port. The pulse and the byte write each have a variant that first waits one second, where the second is a cycle count set by the parameter `CLK_HZ`.

A serial front end builds the command words. It watches `busy` and must not issue a new command while that flag is high, because such a command is discarded. A read reports its result as a single bit with a one-cycle strobe. A command with an undefined opcode leaves the executor idle and raises a one-cycle error flag.

Top module: `io_cmd_exec`

## Requirements
- R1: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. The opcode is bits [51:49], the port select is bits [48:44] and the count is bits [43:0]. Opcode 000 drives `port_out[select]` to 1, with every other port at 0, for exactly `count` cycles. The pulse starts in the cycle after the accepting edge, and the port then returns to 0.
- R2: A count of zero is treated as one cycle, for both the pulse (000) and the read (100).
- R3: Opcode 001 holds all outputs at 0 for `CLK_HZ` cycles after the accepting edge and then produces the same pulse as opcode 000.
- R4: Opcode 100 accepted at edge k raises `rd_valid` for exactly one cycle after edge k+count. `rd_bit` then carries `port_in[select]` as sampled at edge k+count.
- R5: Opcode 011 drives an 8-bit value for exactly the one cycle after the accepting edge. The value is in bits [7:0], and bit [8] is ignored. Value bit i goes to the port named by the 5-bit select at bits [9+5i+4 : 9+5i], for i = 0..7. Ports that no lane selects are 0.
- R6: When two lanes of a byte write select the same port, the lane with the higher index sets that port.
- R7: Opcode 111 holds all outputs at 0 for `CLK_HZ` cycles after the accepting edge and then performs the byte write of opcode 011.
- R8: Opcodes 010, 101 and 110 are not executed. `busy` stays low, and `bad_op` is high for the one cycle after the edge.
- R9: A command presented while `busy` is high is dropped. It changes no output, it does not run later, and it never raises `bad_op`.
- R10: After reset, and whenever `busy` is low, `port_out` is all zeros. `busy` is high from the cycle after an accepting edge until the last cycle of the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 52 | Command: opcode, select and count or byte fields |
| port_in | input | 32 | Input port bank sampled by reads |
| port_out | output | 32 | Output port bank |
| busy | output | 1 | Executor is running a command |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_bit | output | 1 | Sampled input bit |
| bad_op | output | 1 | One-cycle flag for an undefined opcode |

## Verification
Every result is due at a known distance from the accepting edge. A pulse or byte write appears one cycle after that edge. The delayed variants appear after a further `CLK_HZ` cycles. A read result appears count+1 cycles after the edge, and an error flag appears one cycle after it. The bench drives and samples on falling edges and walks cycle by cycle from the accepting edge, checking each cycle of the wait and the active window. For reads it changes the input just before the sampling edge, which shows that the value taken is the one present at edge k+count.

// File: rtl/io_cmd_pkg.sv
package io_cmd_pkg;
  localparam int CMD_W  = 52;
  localparam int AUX_W  = 44;
  localparam int PORT_N = 32;
  localparam int SEL_W  = $clog2(PORT_N);
  localparam int LANES  = 8;
  localparam int LANE0  = 9;

  typedef enum logic [1:0] {K_PULSE, K_READ, K_BYTE} op_kind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_PREWAIT, ST_PULSE, ST_RDWAIT, ST_BYTE} exec_st_e;

  function automatic logic [AUX_W-1:0] sat_count(input logic [AUX_W-1:0] aux);
    return (aux == '0) ? AUX_W'(1) : aux;
  endfunction

  function automatic logic [PORT_N-1:0] one_port(input logic [SEL_W-1:0] sel);
    logic [PORT_N-1:0] v;
    v = '0;
    v[sel] = 1'b1;
    return v;
  endfunction

  // lower lanes first, so a higher lane overwrites a shared port
  function automatic logic [PORT_N-1:0] scatter(input logic [LANES-1:0][SEL_W-1:0] sels,
                                                input logic [LANES-1:0] val);
    logic [PORT_N-1:0] v;
    v = '0;
    for (int i = 0; i < LANES; i++) v[sels[i]] = val[i];
    return v;
  endfunction
endpackage

// File: rtl/io_cmd_decode.sv
module io_cmd_decode
  import io_cmd_pkg::*;
(
  input  logic [CMD_W-1:0]             cmd_word,
  output logic                         legal,
  output logic                         delayed,
  output op_kind_e                     kind,
  output logic [SEL_W-1:0]             sel,
  output logic [AUX_W-1:0]             count,
  output logic [LANES-1:0][SEL_W-1:0]  lanes,
  output logic [LANES-1:0]             value
);
  logic [2:0] opc;
  logic       unused_pad;

  assign opc        = cmd_word[CMD_W-1 -: 3];
  assign sel        = cmd_word[AUX_W +: SEL_W];
  assign count      = sat_count(cmd_word[AUX_W-1:0]);
  assign value      = cmd_word[LANES-1:0];
  assign unused_pad = cmd_word[LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lanes[i] = cmd_word[LANE0 + SEL_W*i +: SEL_W];
  end

  always_comb begin
    legal   = 1'b1;
    delayed = 1'b0;
    kind    = K_PULSE;
    unique case (opc)
      3'b000: kind = K_PULSE;
      3'b001: begin kind = K_PULSE; delayed = 1'b1; end
      3'b100: kind = K_READ;
      3'b011: kind = K_BYTE;
      3'b111: begin kind = K_BYTE; delayed = 1'b1; end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/io_cmd_timer.sv
module io_cmd_timer #(
  parameter int W = 44
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == W'(1));

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/io_cmd_exec.sv
module io_cmd_exec
  import io_cmd_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [PORT_N-1:0] port_in,
  output logic [PORT_N-1:0] port_out,
  output logic              busy,
  output logic              rd_valid,
  output logic              rd_bit,
  output logic              bad_op
);
  localparam logic [AUX_W-1:0] WAIT_1S = AUX_W'(CLK_HZ);

  logic                        dec_legal, dec_delayed;
  op_kind_e                    dec_kind;
  logic [SEL_W-1:0]            dec_sel;
  logic [AUX_W-1:0]            dec_count;
  logic [LANES-1:0][SEL_W-1:0] dec_lanes;
  logic [LANES-1:0]            dec_value;

  io_cmd_decode u_dec (
    .cmd_word (cmd_word),
    .legal    (dec_legal),
    .delayed  (dec_delayed),
    .kind     (dec_kind),
    .sel      (dec_sel),
    .count    (dec_count),
    .lanes    (dec_lanes),
    .value    (dec_value)
  );

  exec_st_e                    state, state_nx;
  op_kind_e                    kind_q;
  logic [SEL_W-1:0]            sel_q;
  logic [AUX_W-1:0]            count_q;
  logic [LANES-1:0][SEL_W-1:0] lanes_q;
  logic [LANES-1:0]            value_q;

  // named events
  logic ev_accept, ev_illegal, ev_drop, ev_wait_done, ev_last;
  logic tmr_load;
  logic [AUX_W-1:0] tmr_val;

  assign busy         = (state != ST_IDLE);
  assign ev_accept    = cmd_valid && !busy && dec_legal;
  assign ev_illegal   = cmd_valid && !busy && !dec_legal;
  assign ev_drop      = cmd_valid && busy;
  assign ev_wait_done = (state == ST_PREWAIT) && ev_last;

  function automatic exec_st_e start_state(input op_kind_e k);
    unique case (k)
      K_PULSE: return ST_PULSE;
      K_READ:  return ST_RDWAIT;
      default: return ST_BYTE;
    endcase
  endfunction

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = count_q;
    unique case (state)
      ST_IDLE: if (ev_accept) begin
        tmr_load = 1'b1;
        tmr_val  = dec_delayed ? WAIT_1S : dec_count;
        state_nx = dec_delayed ? ST_PREWAIT : start_state(dec_kind);
      end
      ST_PREWAIT: if (ev_last) begin
        tmr_load = 1'b1;
        state_nx = start_state(kind_q);
      end
      ST_PULSE, ST_RDWAIT: if (ev_last) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  io_cmd_timer #(.W(AUX_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (ev_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind_q   <= K_PULSE;
      sel_q    <= '0;
      count_q  <= '0;
      lanes_q  <= '0;
      value_q  <= '0;
      rd_valid <= 1'b0;
      rd_bit   <= 1'b0;
      bad_op   <= 1'b0;
    end else begin
      state    <= state_nx;
      bad_op   <= ev_illegal;
      rd_valid <= (state == ST_RDWAIT) && ev_last;
      if ((state == ST_RDWAIT) && ev_last) rd_bit <= port_in[sel_q];
      if (ev_accept) begin
        kind_q  <= dec_kind;
        sel_q   <= dec_sel;
        count_q <= dec_count;
        lanes_q <= dec_lanes;
        value_q <= dec_value;
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_PULSE: port_out = one_port(sel_q);
      ST_BYTE:  port_out = scatter(lanes_q, value_q);
      default:  port_out = '0;
    endcase
  end

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (port_out == '0));
  p_pulse_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PULSE) |-> $onehot(port_out));
  p_rd_after_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(state == ST_RDWAIT));
  p_byte_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BYTE) |=> (state != ST_BYTE));
  p_bad_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> !busy);
  p_drop_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> !bad_op);
  p_wait_to_work_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wait_done |=> (state == ST_PULSE || state == ST_BYTE));
endmodule

// File: tb/io_cmd_exec_bench.sv
module io_cmd_exec_bench;
  localparam int HZ = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [51:0] cmd_word = '0;
  logic [31:0] port_in = '0;
  logic [31:0] port_out;
  logic        busy, rd_valid, rd_bit, bad_op;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  io_cmd_exec #(.CLK_HZ(HZ)) u_io_cmd_exec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .port_in(port_in), .port_out(port_out), .busy(busy),
    .rd_valid(rd_valid), .rd_bit(rd_bit), .bad_op(bad_op)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [51:0] mk_single(input logic [2:0] op, input logic [4:0] sel,
                                            input logic [43:0] aux);
    return {op, sel, aux};
  endfunction

  function automatic logic [51:0] mk_byte(input logic [2:0] op, input logic [7:0][4:0] s,
                                          input logic [7:0] v);
    logic [51:0] w;
    w = '0;
    w[51:49] = op;
    for (int i = 0; i < 8; i++) w[9 + 5*i +: 5] = s[i];
    w[8] = 1'b1;  // ignored bit
    w[7:0] = v;
    return w;
  endfunction

  // highest lane claims a port first
  function automatic logic [31:0] exp_byte(input logic [7:0][4:0] s, input logic [7:0] v);
    logic [31:0] e, taken;
    e = '0; taken = '0;
    for (int i = 7; i >= 0; i--) if (!taken[s[i]]) begin
      taken[s[i]] = 1'b1;
      e[s[i]] = v[i];
    end
    return e;
  endfunction

  // returns at the falling edge just after the accepting edge
  task automatic send(input logic [51:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle_wait(input int n, input string req);
    for (int j = 0; j < n; j++) begin
      chk(port_out == 0 && busy, req, {port_out, 31'b0, busy}, {32'h0, 32'h1});
      @(negedge clk);
    end
  endtask

  task automatic pulse_window(input logic [4:0] sel, input int n, input string req);
    for (int j = 0; j < n; j++) begin
      chk(port_out == (32'h1 << sel) && busy, req, port_out, 32'h1 << sel);
      @(negedge clk);
    end
    chk(port_out == 0 && !busy, req, {port_out, 31'b0, busy}, 64'h0);
  endtask

  task automatic t_reset;
    chk(port_out == 0 && !busy && !rd_valid && !bad_op, "R10",
        {port_out, 28'b0, busy, rd_valid, rd_bit, bad_op}, 64'h0);
  endtask

  task automatic t_pulse;
    send(mk_single(3'b000, 5'd5, 44'd4));
    pulse_window(5'd5, 4, "R1");
    send(mk_single(3'b000, 5'd31, 44'd2));
    pulse_window(5'd31, 2, "R1");
  endtask

  task automatic t_zero_count;
    send(mk_single(3'b000, 5'd0, 44'd0));
    pulse_window(5'd0, 1, "R2");
    send(mk_single(3'b100, 5'd2, 44'd0));
    port_in[2] = 1'b1;
    chk(!rd_valid && busy, "R2", {rd_valid, busy}, 2'b01);
    @(negedge clk);
    chk(rd_valid && rd_bit && !busy, "R2", {rd_valid, rd_bit, busy}, 3'b110);
    port_in = '0;
  endtask

  task automatic t_delay_pulse;
    send(mk_single(3'b001, 5'd12, 44'd3));
    idle_wait(HZ, "R3");
    pulse_window(5'd12, 3, "R3");
  endtask

  task automatic t_read(input logic level);
    port_in = '0;
    port_in[9] = ~level;
    send(mk_single(3'b100, 5'd9, 44'd3));
    for (int j = 0; j < 3; j++) begin
      chk(!rd_valid && busy, "R4", {rd_valid, busy}, 2'b01);
      if (j == 2) port_in[9] = level;
      @(negedge clk);
    end
    port_in[9] = ~level;
    chk(rd_valid && rd_bit == level && !busy, "R4", {rd_valid, rd_bit, busy}, {1'b1, level, 1'b0});
    @(negedge clk);
    chk(!rd_valid, "R4", rd_valid, 0);
    port_in = '0;
  endtask

  task automatic t_byte(input logic [2:0] op, input logic [7:0][4:0] s, input logic [7:0] v,
                        input string req);
    logic [31:0] e;
    e = exp_byte(s, v);
    send(mk_byte(op, s, v));
    if (op == 3'b111) idle_wait(HZ, req);
    chk(port_out == e && busy, req, port_out, e);
    @(negedge clk);
    chk(port_out == 0 && !busy, req, port_out, 0);
  endtask

  task automatic t_collide;
    logic [7:0][4:0] s;
    s = {5'd3, 5'd10, 5'd20, 5'd21, 5'd22, 5'd23, 5'd10, 5'd3};
    send(mk_byte(3'b011, s, 8'h80));  // lane7 high on port 3, lane0 low
    chk(port_out[3] == 1'b1, "R6", port_out, 32'h8);
    @(negedge clk);
    send(mk_byte(3'b011, s, 8'h02));  // lane1 high on port 10, lane6 low
    chk(port_out[10] == 1'b0 && port_out == exp_byte(s, 8'h02), "R6", port_out, exp_byte(s, 8'h02));
    @(negedge clk);
  endtask

  task automatic t_illegal(input logic [2:0] op);
    send(mk_single(op, 5'd7, 44'd5));
    chk(bad_op && !busy && port_out == 0, "R8", {bad_op, busy, port_out}, {2'b10, 32'h0});
    @(negedge clk);
    chk(!bad_op && !busy, "R8", {bad_op, busy}, 2'b00);
  endtask

  task automatic t_drop;
    logic [7:0][4:0] s;
    s = {5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8};
    send(mk_single(3'b000, 5'd17, 44'd6));
    cmd_valid = 1'b1; cmd_word = mk_byte(3'b011, s, 8'hFF);
    @(negedge clk);
    cmd_word = mk_single(3'b010, 5'd0, 44'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!bad_op && port_out == (32'h1 << 17), "R9", {bad_op, port_out}, {1'b0, 32'h1 << 17});
    pulse_window(5'd17, 4, "R9");
    @(negedge clk);
    chk(port_out == 0 && !busy && !bad_op, "R9", {port_out, busy, bad_op}, 0);
  endtask

  initial begin
    logic [7:0][4:0] s;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pulse();
    t_zero_count();
    t_delay_pulse();
    t_read(1'b1);
    t_read(1'b0);
    s = {5'd30, 5'd25, 5'd19, 5'd14, 5'd11, 5'd6, 5'd4, 5'd0};
    t_byte(3'b011, s, 8'hA5, "R5");
    t_byte(3'b011, s, 8'h5A, "R5");
    t_collide();
    t_byte(3'b111, s, 8'hC3, "R7");
    t_illegal(3'b010);
    t_illegal(3'b101);
    t_illegal(3'b110);
    t_drop();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule